// File: doc/BRIEF.md
# Executed-Instruction Address History

This block keeps a short record of where the processor has just been. Each time the core retires an instruction, it raises an executed strobe along with that instruction's 32-bit address. The block writes the address into a small ring of registers and overwrites the oldest entry once the ring is full. Instructions that are fetched but killed never raise the strobe, so they never appear in the record.

When the core halts for debugging, the debug flag rises and the record freezes. A debugger then reads the entries one at a time through a single output word. Each read strobe moves a read pointer to the next entry. The first entry shown is the oldest and the last is the newest, and a full lap of reads brings the pointer back to its starting entry. Two more registers snapshot the current fetch address and decode address on every running cycle. They hold their values for the whole halt.

Top module: `history_buffer`

## Requirements
- R1: While reset is active, and on the first cycle after it, `hist_data`, `fetch_hold` and `decode_hold` are all zero, and every history entry reads zero.
- R2: The ring keeps the addresses of the five most recent cycles on which `exec_valid` was high outside debug mode. A sixth such write replaces the oldest of them.
- R3: In debug mode, each cycle with `rd_strobe` high moves the read pointer to the next entry, and the pointer wraps from entry 4 to entry 0. Five reads return `hist_data` to the entry it showed before them.
- R4: On debug entry `hist_data` shows the oldest recorded address. After k reads it shows the k-th next older-to-newer entry, so the newest address appears after four reads and is the fifth value seen. With no read, the pointer and `hist_data` do not change.
- R5: Outside debug mode, `rd_strobe` has no effect. The read pointer follows the write position, so `hist_data` shows the oldest entry one cycle after each clock edge.
- R6: A cycle with `exec_valid` low leaves the record unchanged. A killed instruction, which never raises the strobe, is therefore not recorded.
- R7: In debug mode, `exec_valid` is ignored and the entries stay frozen. Only reads move the pointer.
- R8: Outside debug mode, `fetch_hold` and `decode_hold` take the values of `fetch_addr` and `decode_addr` at each clock edge. In debug mode they keep the values captured at the last running edge.
- R9: With fewer than five recorded executions since reset, the entries not yet written read as zero and come first in the read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_valid | input | 1 | An instruction completed execution this cycle |
| exec_addr | input | 32 | Address of the completed instruction |
| fetch_addr | input | 32 | Address currently being fetched |
| decode_addr | input | 32 | Address of the instruction now in the instruction latch |
| debug_mode | input | 1 | High while the core is halted for debugging |
| rd_strobe | input | 1 | Debugger read of the history word; advances the pointer |
| hist_data | output | 32 | History entry selected by the read pointer |
| fetch_hold | output | 32 | Fetch address captured at the last running edge |
| decode_hold | output | 32 | Decode address captured at the last running edge |

## Verification
The bench reads more than five times during one halt, so that it crosses the 4-to-0 wrap. A pointer that stepped into slots 5 to 7, or restarted at the wrong entry, would show a stale or zero word where a recorded address belongs. It raises `exec_valid` while halted and `rd_strobe` while running. A design that let either through would change the record or shift the read order that the reference queue predicts. It also enters debug both after fewer than five executions and after the ring has wrapped many times. An off-by-one in the follow pointer would put the newest address first rather than last. Fetch and decode addresses change on every cycle, so a snapshot that kept updating during a halt would be visible at once.

// File: rtl/hist_pkg.sv
package hist_pkg;

    // Operating state of the core as seen by the history logic.
    typedef enum logic [0:0] {
        CORE_RUN  = 1'b0,
        CORE_HALT = 1'b1
    } core_state_e;

    function automatic core_state_e state_of(input logic halted);
        return halted ? CORE_HALT : CORE_RUN;
    endfunction

endpackage

// File: rtl/hist_ring.sv
module hist_ring #(
    parameter int AW    = 32,
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [AW-1:0] rd_data,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] wr_idx_next
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] slot;
        logic [PW-1:0]            wptr;
    } ring_t;

    ring_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (s_q.wptr == PW'(i)) begin
                    s_d.slot[i] = wr_data;
                end
            end
            s_d.wptr = (s_q.wptr == LAST) ? '0 : s_q.wptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == PW'(i)) begin
                rd_data = s_q.slot[i];
            end
        end
    end

    assign wr_idx      = s_q.wptr;
    assign wr_idx_next = s_d.wptr;

    AST_WPTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wptr <= LAST);                                              // R2
    AST_IDLE_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.slot) && $stable(s_q.wptr));             // R6

endmodule

// File: rtl/hist_rdptr.sv
module hist_rdptr #(
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halted,
    input  logic          rd_req,
    input  logic [PW-1:0] follow_idx,
    output logic [PW-1:0] rd_idx
);
    import hist_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } rdp_t;

    rdp_t        p_d, p_q;
    core_state_e st;

    assign st = state_of(halted);

    always_comb begin
        p_d = p_q;
        unique case (st)
            CORE_RUN:  p_d.ptr = follow_idx;
            CORE_HALT: begin
                if (rd_req) begin
                    p_d.ptr = (p_q.ptr == LAST) ? '0 : p_q.ptr + 1'b1;
                end
            end
            default:   p_d.ptr = p_q.ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rd_idx = p_q.ptr;

    AST_RDPTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        halted && rd_req && (p_q.ptr == LAST) |=> p_q.ptr == '0);       // R3
    AST_RDPTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        halted && rd_req && (p_q.ptr != LAST) |=> p_q.ptr == $past(p_q.ptr) + 1'b1); // R3
    AST_RDPTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !rd_req |=> $stable(p_q.ptr));                        // R4

endmodule

// File: rtl/hist_snap.sv
module hist_snap #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halted,
    input  logic [AW-1:0] fetch_in,
    input  logic [AW-1:0] decode_in,
    output logic [AW-1:0] fetch_out,
    output logic [AW-1:0] decode_out
);
    typedef struct packed {
        logic [AW-1:0] fetch;
        logic [AW-1:0] decode;
    } snap_t;

    snap_t n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (!halted) begin
            n_d.fetch  = fetch_in;
            n_d.decode = decode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0;
        end else begin
            n_q <= n_d;
        end
    end

    assign fetch_out  = n_q.fetch;
    assign decode_out = n_q.decode;

    AST_SNAP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> fetch_out == $past(fetch_in) && decode_out == $past(decode_in)); // R8
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(fetch_out) && $stable(decode_out));          // R8

endmodule

// File: rtl/history_buffer.sv
module history_buffer #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_valid,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] decode_addr,
    input  logic              debug_mode,
    input  logic              rd_strobe,
    output logic [ADDR_W-1:0] hist_data,
    output logic [ADDR_W-1:0] fetch_hold,
    output logic [ADDR_W-1:0] decode_hold
);
    import hist_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] rd_idx;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] wr_idx_next;
    logic             wr_en;

    assign wr_en = exec_valid && (state_of(debug_mode) == CORE_RUN);

    hist_ring #(.AW(ADDR_W), .DEPTH(DEPTH), .PW(PTR_W)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (exec_addr),
        .rd_idx      (rd_idx),
        .rd_data     (hist_data),
        .wr_idx      (wr_idx),
        .wr_idx_next (wr_idx_next)
    );

    hist_rdptr #(.DEPTH(DEPTH), .PW(PTR_W)) u_rdptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (debug_mode),
        .rd_req     (rd_strobe),
        .follow_idx (wr_idx_next),
        .rd_idx     (rd_idx)
    );

    hist_snap #(.AW(ADDR_W)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (debug_mode),
        .fetch_in   (fetch_addr),
        .decode_in  (decode_addr),
        .fetch_out  (fetch_hold),
        .decode_out (decode_hold)
    );

    AST_PTR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_mode |=> rd_idx == wr_idx);                              // R5
    AST_HALT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |=> $stable(wr_idx));                                // R7
    AST_HALT_IDLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode && !rd_strobe |=> $stable(hist_data));               // R4

endmodule

// File: tb/history_buffer_test.sv
`timescale 1ns/1ps
module history_buffer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exec_valid;
    logic [31:0] exec_addr;
    logic [31:0] fetch_addr;
    logic [31:0] decode_addr;
    logic        debug_mode;
    logic        rd_strobe;
    logic [31:0] hist_data;
    logic [31:0] fetch_hold;
    logic [31:0] decode_hold;

    always #2.5 clk = ~clk;

    history_buffer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec_valid  (exec_valid),
        .exec_addr   (exec_addr),
        .fetch_addr  (fetch_addr),
        .decode_addr (decode_addr),
        .debug_mode  (debug_mode),
        .rd_strobe   (rd_strobe),
        .hist_data   (hist_data),
        .fetch_hold  (fetch_hold),
        .decode_hold (decode_hold)
    );

    int          total = 0;
    int          bad   = 0;
    int          cyc   = 0;
    string       phase = "R1";
    logic [31:0] ref_q[$];
    int          ref_off;
    logic [31:0] ref_fetch;
    logic [31:0] ref_decode;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("hist_data", hist_data, ref_q[ref_off]);
        chk("fetch_hold", fetch_hold, ref_fetch);
        chk("decode_hold", decode_hold, ref_decode);
    endtask

    // One clock: drive inputs, apply the reference model at the edge,
    // compare at the following falling edge.
    task automatic tick(input logic v, input logic [31:0] a, input logic dbg, input logic rd);
        exec_valid  = v;
        exec_addr   = a;
        debug_mode  = dbg;
        rd_strobe   = rd;
        fetch_addr  = 32'hF000_0000 + 32'(cyc);
        decode_addr = 32'hD000_0000 + 32'(cyc * 3);
        cyc++;
        @(posedge clk);
        if (!dbg) begin
            if (v) begin
                ref_q.push_back(a);
                void'(ref_q.pop_front());
            end
            ref_off    = 0;
            ref_fetch  = fetch_addr;
            ref_decode = decode_addr;
        end else if (rd) begin
            ref_off = (ref_off + 1) % 5;
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired in phase %s actual=%0d expected=%0d", phase, cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ref_q = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
        ref_off = 0;
        ref_fetch = '0;
        ref_decode = '0;
        rst_n = 1'b0;
        exec_valid = 1'b0;
        exec_addr = '0;
        fetch_addr = 32'hFFFF_FFFF;
        decode_addr = 32'hFFFF_FFFF;
        debug_mode = 1'b0;
        rd_strobe = 1'b0;

        // R1: reset values
        repeat (3) @(negedge clk);
        phase = "R1";
        compare_all();
        rst_n = 1'b1;
        tick(1'b0, '0, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) tick(1'b0, '0, 1'b1, 1'b1);

        // R9: three executions only, unwritten slots read zero first
        phase = "R9";
        tick(1'b1, 32'h0000_1000, 1'b0, 1'b0);
        tick(1'b1, 32'h0000_1004, 1'b0, 1'b1);
        tick(1'b1, 32'h0000_1008, 1'b0, 1'b0);
        tick(1'b0, '0, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) tick(1'b0, '0, 1'b1, 1'b1);

        // R2 / R6: many executions with idle gaps, ring wraps
        phase = "R2";
        for (int k = 0; k < 13; k++) begin
            tick(1'b1, 32'h0002_0000 + 32'(k * 8), 1'b0, 1'b0);
            if (k % 3 == 0) begin
                phase = "R6";
                tick(1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0);
                phase = "R2";
            end
        end

        // R4 / R7: halted, stray executions ignored, reads with pauses
        phase = "R7";
        tick(1'b1, 32'hBAD0_0001, 1'b1, 1'b0);
        tick(1'b1, 32'hBAD0_0002, 1'b1, 1'b0);
        phase = "R4";
        for (int k = 0; k < 4; k++) begin
            tick(1'b0, '0, 1'b1, 1'b1);
            tick(1'b1, 32'hBAD0_0003, 1'b1, 1'b0);
        end

        // R3: keep reading past the 4-to-0 wrap, two full laps
        phase = "R3";
        for (int k = 0; k < 11; k++) tick(1'b0, '0, 1'b1, 1'b1);

        // R5: back to running, reads ignored, pointer tracks oldest
        phase = "R5";
        for (int k = 0; k < 7; k++) begin
            tick(k[0], 32'h0030_0000 + 32'(k), 1'b0, 1'b1);
        end

        // R8: snapshots across a halt and resume
        phase = "R8";
        tick(1'b0, '0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) tick(1'b0, '0, 1'b1, 1'b0);
        tick(1'b0, '0, 1'b0, 1'b0);
        tick(1'b1, 32'h0040_0000, 1'b0, 1'b0);
        tick(1'b0, '0, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) tick(1'b0, '0, 1'b1, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule